// File: doc/BRIEF.md
# Machine Timer and Software Interrupt Unit

This peripheral sits on a 32-bit word bus next to a processor core. It provides a 64-bit time counter that advances every clock and a 64-bit compare value. From these it drives a level timer interrupt. It also holds a single software-interrupt flag that drives a level software interrupt. Each 64-bit quantity is split into a low word and a high word, and each word is written and read on its own. The software flag has one address that sets it and another that clears it. Both addresses read back the same flag.

A bus request is one cycle with `bus_valid` high. A small response state machine answers it in the following cycle. It moves from `RS_IDLE` to `RS_DONE` when the address is mapped, or to `RS_FAULT` when it is not. With no request it returns to `RS_IDLE`. `bus_err` is high only in `RS_FAULT`. Read data is registered and shows up in that same response cycle. In all other cycles it is zero.

Top module: `tsu_top`

## Requirements
- R1: After reset the time counter, the compare value and the software flag are all zero. `irq_timer` is therefore high, and `irq_soft`, `bus_err` and `bus_rdata` are low.
- R2: A write to offset 0x010 with bit 0 set makes the software flag 1. A write there with bit 0 clear leaves the flag as it was.
- R3: A write to offset 0x014 with bit 0 set makes the software flag 0. A write there with bit 0 clear leaves the flag as it was.
- R4: A read of offset 0x010 or offset 0x014 returns the software flag in bit 0 and zeros in bits 31:1. `irq_soft` equals the flag.
- R5: The 64-bit time counter grows by exactly one per clock. It carries from the low word (offset 0x100) into the high word (offset 0x104).
- R6: A write to either time word replaces that word with the written data and keeps the other word. In that cycle the write takes the place of the increment.
- R7: The compare low word (0x108) and high word (0x10C) are each written without touching the other word, and each reads back as written.
- R8: `irq_timer` is high exactly when the time counter is greater than or equal to the compare value, taken as 64-bit unsigned numbers.
- R9: A read or write of any offset other than 0x010, 0x014, 0x100, 0x104, 0x108 and 0x10C gives `bus_err` high in the next cycle with zero read data. It changes no state.
- R10: `bus_rdata` and `bus_err` belong to the request of the previous cycle. Both are zero in a cycle that follows no request, and read data is zero after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Error response, one cycle after the request |
| irq_timer | output | 1 | Level timer interrupt |
| irq_soft | output | 1 | Level software interrupt |

## Verification
The assertions assume that `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` are held stable across each rising edge. They also assume that the time counter never wraps past 2^64 within a run, so a raised timer interrupt can only fall after a write to a time or compare word. The stimulus changes inputs only on falling edges and presents one request per cycle. It never loads the time counter close enough to the 64-bit limit to wrap, so both assumptions hold throughout.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_SW_SET = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_SW_CLR = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_TIME_L = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_TIME_H = 12'h104;
    localparam logic [ADDR_W-1:0] OFF_CMP_L  = 12'h108;
    localparam logic [ADDR_W-1:0] OFF_CMP_H  = 12'h10C;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DONE  = 2'd1,
        RS_FAULT = 2'd2
    } rsp_state_e;

    typedef struct packed {
        logic sw_set;
        logic sw_clr;
        logic time_l;
        logic time_h;
        logic cmp_l;
        logic cmp_h;
        logic hit;
    } reg_sel_t;
endpackage

// File: rtl/tsu_decode.sv
module tsu_decode
    import tsu_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    always_comb begin
        sel        = '0;
        sel.sw_set = (addr == OFF_SW_SET);
        sel.sw_clr = (addr == OFF_SW_CLR);
        sel.time_l = (addr == OFF_TIME_L);
        sel.time_h = (addr == OFF_TIME_H);
        sel.cmp_l  = (addr == OFF_CMP_L);
        sel.cmp_h  = (addr == OFF_CMP_H);
        sel.hit    = sel.sw_set | sel.sw_clr | sel.time_l |
                     sel.time_h | sel.cmp_l  | sel.cmp_h;
    end
endmodule

// File: rtl/tsu_wide_reg.sv
module tsu_wide_reg #(
    parameter int DW       = 32,
    parameter bit COUNT_EN = 1'b0,
    localparam int TW      = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output logic [TW-1:0] q
);
    logic [TW-1:0] idle_next;

    generate
        if (COUNT_EN) begin : g_count
            assign idle_next = q + TW'(1);
        end else begin : g_hold
            assign idle_next = q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr_lo)
            q <= {q[TW-1:DW], wdata};
        else if (wr_hi)
            q <= {wdata, q[DW-1:0]};
        else
            q <= idle_next;
    end
endmodule

// File: rtl/tsu_rsp_fsm.sv
module tsu_rsp_fsm
    import tsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic mapped,
    output logic err
);
    rsp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RS_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        if (!req)
            state_d = RS_IDLE;
        else if (mapped)
            state_d = RS_DONE;
        else
            state_d = RS_FAULT;
    end

    always_comb begin
        unique case (state_q)
            RS_IDLE:  err = 1'b0;
            RS_DONE:  err = 1'b0;
            RS_FAULT: err = 1'b1;
            default:  err = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsu_top.sv
module tsu_top
    import tsu_pkg::*;
#(
    parameter int DW = 32,
    localparam int TW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err,
    output logic              irq_timer,
    output logic              irq_soft
);
    reg_sel_t      sel;
    logic          wr_en;
    logic          rd_en;
    logic [TW-1:0] time_q;
    logic [TW-1:0] cmp_q;
    logic          soft_q;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;

    tsu_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_en = bus_valid &  bus_write;
    assign rd_en = bus_valid & ~bus_write;

    tsu_wide_reg #(.DW(DW), .COUNT_EN(1'b1)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_en & sel.time_l),
        .wr_hi (wr_en & sel.time_h),
        .wdata (bus_wdata),
        .q     (time_q)
    );

    tsu_wide_reg #(.DW(DW), .COUNT_EN(1'b0)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_en & sel.cmp_l),
        .wr_hi (wr_en & sel.cmp_h),
        .wdata (bus_wdata),
        .q     (cmp_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            soft_q <= 1'b0;
        else if (wr_en && sel.sw_set && bus_wdata[0])
            soft_q <= 1'b1;
        else if (wr_en && sel.sw_clr && bus_wdata[0])
            soft_q <= 1'b0;
    end

    always_comb begin
        rd_mux = '0;
        if (sel.sw_set || sel.sw_clr) rd_mux[0] = soft_q;
        if (sel.time_l) rd_mux = time_q[DW-1:0];
        if (sel.time_h) rd_mux = time_q[TW-1:DW];
        if (sel.cmp_l)  rd_mux = cmp_q[DW-1:0];
        if (sel.cmp_h)  rd_mux = cmp_q[TW-1:DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en && sel.hit)
            rdata_q <= rd_mux;
        else
            rdata_q <= '0;
    end

    tsu_rsp_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_valid),
        .mapped (sel.hit),
        .err    (bus_err)
    );

    assign bus_rdata = rdata_q;
    assign irq_timer = (time_q >= cmp_q);
    assign irq_soft  = soft_q;
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker
    import tsu_pkg::*;
#(
    parameter int DW = 32,
    localparam int TW = 2 * DW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic              bus_err,
    input logic              irq_timer,
    input logic              irq_soft,
    input logic [TW-1:0]     time_q,
    input logic [TW-1:0]     cmp_q
);
    logic wr, wr_time, wr_tc, wr_sw, mapped;
    assign wr      = bus_valid && bus_write;
    assign wr_time = wr && (bus_addr == OFF_TIME_L || bus_addr == OFF_TIME_H);
    assign wr_tc   = wr_time || (wr && (bus_addr == OFF_CMP_L || bus_addr == OFF_CMP_H));
    assign wr_sw   = wr && (bus_addr == OFF_SW_SET || bus_addr == OFF_SW_CLR);
    assign mapped  = bus_addr == OFF_SW_SET || bus_addr == OFF_SW_CLR ||
                     bus_addr == OFF_TIME_L || bus_addr == OFF_TIME_H ||
                     bus_addr == OFF_CMP_L  || bus_addr == OFF_CMP_H;

    a_r2_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFF_SW_SET && bus_wdata[0]) |=> irq_soft);

    a_r3_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFF_SW_CLR && bus_wdata[0]) |=> !irq_soft);

    a_r4_soft_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sw |=> $stable(irq_soft));

    a_r5_time_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_time |=> (time_q == $past(time_q) + TW'(1)));

    a_r6_time_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFF_TIME_L) |=>
            (time_q[DW-1:0] == $past(bus_wdata) && time_q[TW-1:DW] == $past(time_q[TW-1:DW])));

    a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (bus_addr == OFF_CMP_L || bus_addr == OFF_CMP_H)) |=> $stable(cmp_q));

    a_r8_timer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_timer && !wr_tc) |=> irq_timer);

    a_r9_unmapped_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !mapped) |=> (bus_err && bus_rdata == '0));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (!bus_err && bus_rdata == '0));
endmodule

bind tsu_top tsu_checker #(.DW(DW)) u_tsu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .irq_timer (irq_timer),
    .irq_soft  (irq_soft),
    .time_q    (time_q),
    .cmp_q     (cmp_q)
);

// File: tb/tb_tsu_top.sv
module tb_tsu_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic        exp_soft;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 12'h010, 32'h0,        32'h0,        1'b0, 1'b0},
        '{1'b1, 12'h010, 32'h2,        32'h0,        1'b0, 1'b0},
        '{1'b0, 12'h014, 32'h0,        32'h0,        1'b0, 1'b0},
        '{1'b1, 12'h010, 32'h1,        32'h0,        1'b0, 1'b1},
        '{1'b0, 12'h014, 32'h0,        32'h1,        1'b0, 1'b1},
        '{1'b0, 12'h010, 32'h0,        32'h1,        1'b0, 1'b1},
        '{1'b1, 12'h014, 32'hFFFFFFFE, 32'h0,        1'b0, 1'b1},
        '{1'b1, 12'h010, 32'h1,        32'h0,        1'b0, 1'b1},
        '{1'b1, 12'h014, 32'h1,        32'h0,        1'b0, 1'b0},
        '{1'b0, 12'h010, 32'h0,        32'h0,        1'b0, 1'b0},
        '{1'b1, 12'h108, 32'h12345678, 32'h0,        1'b0, 1'b0},
        '{1'b1, 12'h10C, 32'h9ABCDEF0, 32'h0,        1'b0, 1'b0},
        '{1'b1, 12'h108, 32'h0BADF00D, 32'h0,        1'b0, 1'b0},
        '{1'b0, 12'h10C, 32'h0,        32'h9ABCDEF0, 1'b0, 1'b0},
        '{1'b0, 12'h108, 32'h0,        32'h0BADF00D, 1'b0, 1'b0},
        '{1'b0, 12'h00C, 32'h0,        32'h0,        1'b1, 1'b0},
        '{1'b1, 12'h018, 32'h1,        32'h0,        1'b1, 1'b0},
        '{1'b0, 12'h110, 32'h0,        32'h0,        1'b1, 1'b0},
        '{1'b1, 12'h012, 32'h1,        32'h0,        1'b1, 1'b0},
        '{1'b0, 12'h104, 32'h0,        32'h0,        1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_timer;
    logic        irq_soft;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tsu_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .irq_timer (irq_timer),
        .irq_soft  (irq_soft)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one request at a falling edge; returns at the next falling edge
    // with the response of that request on the outputs.
    task automatic op(input logic wr, input logic [11:0] addr, input logic [31:0] data);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = addr;
        bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values seen while in reset
        chk(irq_timer == 1'b1, "R1 irq_timer", 32'(irq_timer), 32'h1);
        chk(irq_soft == 1'b0, "R1 irq_soft", 32'(irq_soft), 32'h0);
        chk(bus_err == 1'b0 && bus_rdata == '0, "R1 bus idle", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: no request gives quiet outputs
        chk(bus_err == 1'b0 && bus_rdata == '0, "R10 idle", bus_rdata, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            op(VEC[i].wr, VEC[i].addr, VEC[i].wdata);
            // R2 R3 R4 R7 R9: table walk
            chk(bus_err == VEC[i].exp_err, "R9 err", 32'(bus_err), 32'(VEC[i].exp_err));
            chk(bus_rdata == VEC[i].exp_rd, "R4/R7/R10 rdata", bus_rdata, VEC[i].exp_rd);
            chk(irq_soft == VEC[i].exp_soft, "R2/R3 soft", 32'(irq_soft), 32'(VEC[i].exp_soft));
        end
        @(negedge clk);
        chk(bus_err == 1'b0 && bus_rdata == '0, "R10 quiet after table", bus_rdata, 32'h0);

        // R8: boundary greater-or-equal
        op(1'b1, 12'h10C, 32'h0);
        op(1'b1, 12'h108, 32'd200);
        op(1'b1, 12'h104, 32'h0);
        op(1'b1, 12'h100, 32'd197);
        chk(irq_timer == 1'b0, "R8 time 197 < 200", 32'(irq_timer), 32'h0);
        @(negedge clk);
        @(negedge clk);
        chk(irq_timer == 1'b0, "R8 time 199 < 200", 32'(irq_timer), 32'h0);
        @(negedge clk);
        chk(irq_timer == 1'b1, "R8 time 200 >= 200", 32'(irq_timer), 32'h1);
        // R6: write then read returns the written word exactly
        op(1'b1, 12'h100, 32'h00001000);
        op(1'b0, 12'h100, 32'h0);
        chk(bus_rdata == 32'h00001000, "R6 write wins", bus_rdata, 32'h00001000);

        // R8: unsigned comparison in the high word
        op(1'b1, 12'h10C, 32'h80000000);
        op(1'b1, 12'h104, 32'h00000001);
        chk(irq_timer == 1'b0, "R8 unsigned below", 32'(irq_timer), 32'h0);
        op(1'b1, 12'h104, 32'hFFFFFFF0);
        chk(irq_timer == 1'b1, "R8 unsigned above", 32'(irq_timer), 32'h1);

        // R5 R6: carry from low word into high word
        op(1'b1, 12'h104, 32'h5);
        op(1'b1, 12'h100, 32'hFFFFFFFE);
        op(1'b0, 12'h100, 32'h0);
        chk(bus_rdata == 32'hFFFFFFFE, "R6 low written", bus_rdata, 32'hFFFFFFFE);
        op(1'b0, 12'h104, 32'h0);
        chk(bus_rdata == 32'h5, "R6 high kept", bus_rdata, 32'h5);
        op(1'b0, 12'h104, 32'h0);
        chk(bus_rdata == 32'h6, "R5 carry", bus_rdata, 32'h6);
        op(1'b0, 12'h100, 32'h0);
        chk(bus_rdata == 32'h1, "R5 step", bus_rdata, 32'h1);

        // R1: reset again mid-run clears everything
        op(1'b1, 12'h010, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(irq_soft == 1'b0 && irq_timer == 1'b1, "R1 reapplied", {30'h0, irq_soft, irq_timer}, 32'h1);
        rst_n = 1'b1;
        op(1'b0, 12'h10C, 32'h0);
        chk(bus_rdata == 32'h0, "R1 cmp zero", bus_rdata, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule